// File: doc/BRIEF.md
# Quadrature Multiply-Accumulate Response Analyzer

This block is the output-response side of an on-chip analog self-test. It measures one spectral component of a sampled response. Each valid sample from the converter under test is multiplied by two reference values from an external oscillator. The in-phase reference is a sine and the quadrature reference is the matching cosine, both at the test frequency. Each product is added into its own accumulator. After a run, the two sums are the real and imaginary parts of the response at that frequency. Magnitude and phase are worked out downstream. To sweep a band, the controller reprograms the oscillator frequency and starts a new run for each point. The step between points sets the frequency resolution.

A test controller drives the block. It pulses `start_i` and presents the sample count K on `count_i` in the same cycle. It then waits for a one-cycle `done_o` pulse and reads both sums. The sums stay frozen until the next start.

The controller has three states:
- **IDLE**: results held, samples ignored.
- **ACCUM**: valid samples are summed.
- **DONE**: a one-cycle completion state.

Transitions:
- **START_RUN**: any state to ACCUM, on start with K > 0.
- **START_EMPTY**: any state to DONE, on start with K = 0.
- **LAST_SAMPLE**: ACCUM to DONE, on the K-th valid sample.
- **RETIRE**: DONE to IDLE, when no start is present.

Top module: `qmac_analyzer`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o` and `done_o` are 0 and both accumulators read 0.
- R2: A start clears both accumulators and latches `count_i` as K. From the next cycle, `busy_o` is 1 when K > 0.
- R3: In ACCUM, each cycle with `sample_valid_i` = 1 adds sample×`ref_inph_i` to `acc_inph_o` and sample×`ref_quad_i` to `acc_quad_o`. All operands are signed two's complement. The new sums are visible in the cycle after the sample.
- R4: In ACCUM, a cycle with `sample_valid_i` = 0 changes neither accumulator and does not count toward K.
- R5: After exactly K valid samples, `done_o` is 1 for one cycle. That cycle follows the cycle of the K-th sample, and `busy_o` is 0 in it.
- R6: Each product is sign-extended to the accumulator width before it is added. Sums wrap modulo 2^ACC_W with no saturation.
- R7: Outside ACCUM, both results hold their values and samples are ignored, until the next start.
- R8: A start with K = 0 gives `done_o` = 1 in the next cycle, with both results at 0 and `busy_o` at 0.
- R9: A start during ACCUM restarts the run with the new K. A start overrides a valid sample in the same cycle, and that sample is not accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse: clears the sums and latches K |
| count_i | input | CNT_W | Number of valid samples to accumulate (K) |
| sample_valid_i | input | 1 | Marks `sample_i` as a valid sample |
| sample_i | input | DATA_W | Response sample, signed |
| ref_inph_i | input | REF_W | In-phase (sine) reference, signed |
| ref_quad_i | input | REF_W | Quadrature (cosine) reference, signed |
| busy_o | output | 1 | High in ACCUM |
| done_o | output | 1 | One-cycle completion pulse |
| acc_inph_o | output | ACC_W | In-phase sum (real part), signed |
| acc_quad_o | output | ACC_W | Quadrature sum (imaginary part), signed |

## Verification
The two sums are registered outputs, so a fault shows up at the ports within one cycle:
- A wrong product, missing sign extension or a skipped clear gives a wrong sum in the cycle after the offending sample.
- A remaining-sample counter that is off by one moves the `done_o` pulse by one cycle. The same fault also accepts or drops one product, which changes the final sums.
- A state that fails to leave DONE, or leaves IDLE by itself, shows as `done_o` wider than one cycle or as results that change after completion.

The reference model is compared against the ports on every clock, so each of these faults is caught in the cycle it first appears.

// File: rtl/qmac_pkg.sv
package qmac_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ACCUM = 2'd1,
        S_DONE  = 2'd2
    } qmac_state_e;

    localparam int unsigned LANES = 2;

endpackage

// File: rtl/qmac_ctrl.sv
module qmac_ctrl
    import qmac_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             valid_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             clear_o,
    output logic             accum_en_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    qmac_state_e      state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;

    // next-state logic; a start overrides every other event
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        if (start_i) begin
            if (count_i == '0) begin
                state_d = S_DONE;          // START_EMPTY
                left_d  = '0;
            end else begin
                state_d = S_ACCUM;         // START_RUN
                left_d  = count_i;
            end
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    state_d = S_IDLE;
                end
                S_ACCUM: begin
                    if (valid_i) begin
                        left_d = left_q - ONE;
                        if (left_q == ONE) begin
                            state_d = S_DONE;   // LAST_SAMPLE
                        end
                    end
                end
                S_DONE: begin
                    state_d = S_IDLE;           // RETIRE
                end
                default: begin
                    state_d = S_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q == S_ACCUM);
        done_o     = (state_q == S_DONE);
        clear_o    = start_i;
        accum_en_o = !start_i && (state_q == S_ACCUM) && valid_i;
    end

endmodule

// File: rtl/qmac_product.sv
module qmac_product #(
    parameter int DATA_W = 12,
    parameter int REF_W  = 12,
    parameter int ACC_W  = 40
) (
    input  logic signed [DATA_W-1:0] sample_i,
    input  logic signed [REF_W-1:0]  ref_i,
    output logic signed [ACC_W-1:0]  term_o
);

    localparam int PROD_W = DATA_W + REF_W;

    logic signed [PROD_W-1:0] prod;

    assign prod = sample_i * ref_i;

    generate
        if (ACC_W > PROD_W) begin : g_extend
            assign term_o = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        end else if (ACC_W == PROD_W) begin : g_exact
            assign term_o = prod;
        end else begin : g_trunc
            assign term_o = prod[ACC_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/qmac_accum.sv
module qmac_accum #(
    parameter int ACC_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    en_i,
    input  logic signed [ACC_W-1:0] term_i,
    output logic signed [ACC_W-1:0] acc_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (clear_i) begin
            acc_o <= '0;
        end else if (en_i) begin
            acc_o <= acc_o + term_i;   // two's-complement wrap
        end
    end

endmodule

// File: rtl/qmac_analyzer.sv
module qmac_analyzer
    import qmac_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int REF_W  = 12,
    parameter int ACC_W  = 40,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              sample_valid_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [REF_W-1:0]  ref_inph_i,
    input  logic [REF_W-1:0]  ref_quad_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ACC_W-1:0]  acc_inph_o,
    output logic [ACC_W-1:0]  acc_quad_o
);

    logic clear;
    logic accum_en;

    logic signed [REF_W-1:0] ref_lane  [LANES];
    logic signed [ACC_W-1:0] term_lane [LANES];
    logic signed [ACC_W-1:0] acc_lane  [LANES];

    assign ref_lane[0] = ref_inph_i;
    assign ref_lane[1] = ref_quad_i;

    qmac_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .count_i    (count_i),
        .valid_i    (sample_valid_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .clear_o    (clear),
        .accum_en_o (accum_en)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qmac_product #(
            .DATA_W (DATA_W),
            .REF_W  (REF_W),
            .ACC_W  (ACC_W)
        ) u_prod (
            .sample_i (sample_i),
            .ref_i    (ref_lane[g]),
            .term_o   (term_lane[g])
        );

        qmac_accum #(
            .ACC_W (ACC_W)
        ) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear),
            .en_i    (accum_en),
            .term_i  (term_lane[g]),
            .acc_o   (acc_lane[g])
        );
    end

    assign acc_inph_o = acc_lane[0];
    assign acc_quad_o = acc_lane[1];

endmodule

// File: rtl/qmac_analyzer_chk.sv
module qmac_analyzer_chk #(
    parameter int DATA_W = 12,
    parameter int REF_W  = 12,
    parameter int ACC_W  = 40,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CNT_W-1:0]  count_i,
    input logic              sample_valid_i,
    input logic [DATA_W-1:0] sample_i,
    input logic [REF_W-1:0]  ref_inph_i,
    input logic [REF_W-1:0]  ref_quad_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [ACC_W-1:0]  acc_inph_o,
    input logic [ACC_W-1:0]  acc_quad_o
);

    // R1: no activity while reset is asserted
    always @(negedge clk) begin
        if (!rst_n && $past(!rst_n)) begin
            p_reset_idle_r1: assert (!busy_o && !done_o);
        end
    end

    p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (acc_inph_o == '0) && (acc_quad_o == '0));

    p_start_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (count_i != '0) |=> busy_o && !done_o);

    p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (count_i == '0) |=> done_o && !busy_o);

    p_gap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !sample_valid_i && !start_i |=>
            $stable(acc_inph_o) && $stable(acc_quad_o));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> !done_o);

    p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i |=> $stable(acc_inph_o) && $stable(acc_quad_o));

endmodule

bind qmac_analyzer qmac_analyzer_chk #(
    .DATA_W (DATA_W),
    .REF_W  (REF_W),
    .ACC_W  (ACC_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .count_i        (count_i),
    .sample_valid_i (sample_valid_i),
    .sample_i       (sample_i),
    .ref_inph_i     (ref_inph_i),
    .ref_quad_i     (ref_quad_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .acc_inph_o     (acc_inph_o),
    .acc_quad_o     (acc_quad_o)
);

// File: tb/tb_qmac_analyzer.sv
`timescale 1ns/1ps
module tb_qmac_analyzer;

    localparam int DATA_W = 12;
    localparam int REF_W  = 12;
    localparam int ACC_W  = 28;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CNT_W-1:0]  count_i = '0;
    logic              sample_valid_i = 1'b0;
    logic [DATA_W-1:0] sample_i = '0;
    logic [REF_W-1:0]  ref_inph_i = '0;
    logic [REF_W-1:0]  ref_quad_i = '0;
    logic              busy_o;
    logic              done_o;
    logic [ACC_W-1:0]  acc_inph_o;
    logic [ACC_W-1:0]  acc_quad_o;

    int  n_checks = 0;
    int  n_errors = 0;
    int  cycles   = 0;
    bit  finished = 1'b0;

    longint sum_re, sum_im;

    always #2.5 clk = ~clk;   // 200 MHz

    qmac_analyzer #(
        .DATA_W (DATA_W),
        .REF_W  (REF_W),
        .ACC_W  (ACC_W),
        .CNT_W  (CNT_W)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .count_i        (count_i),
        .sample_valid_i (sample_valid_i),
        .sample_i       (sample_i),
        .ref_inph_i     (ref_inph_i),
        .ref_quad_i     (ref_quad_i),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .acc_inph_o     (acc_inph_o),
        .acc_quad_o     (acc_quad_o)
    );

    function automatic longint wrapv(longint v);
        logic signed [ACC_W-1:0] t;
        t = ACC_W'(v);
        return longint'(t);
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // ---------------- cycle reference model ----------------
    bit     m_busy = 1'b0, m_done = 1'b0;
    longint m_re = 0, m_im = 0;
    int     m_left = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_re <= 0; m_im <= 0; m_left <= 0;
        end else begin
            m_done <= 1'b0;
            if (start_i) begin
                m_re <= 0; m_im <= 0;
                if (count_i == 0) begin
                    m_busy <= 1'b0; m_done <= 1'b1;
                end else begin
                    m_busy <= 1'b1; m_left <= int'(count_i);
                end
            end else if (m_busy && sample_valid_i) begin
                m_re <= wrapv(m_re + longint'($signed(sample_i)) * longint'($signed(ref_inph_i)));
                m_im <= wrapv(m_im + longint'($signed(sample_i)) * longint'($signed(ref_quad_i)));
                m_left <= m_left - 1;
                if (m_left == 1) begin
                    m_busy <= 1'b0; m_done <= 1'b1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R5", "done_o vs model", longint'(done_o), longint'(m_done));
            check("R2", "busy_o vs model", longint'(busy_o), longint'(m_busy));
            check("R3", "acc_inph vs model", longint'($signed(acc_inph_o)), m_re);
            check("R3", "acc_quad vs model", longint'($signed(acc_quad_o)), m_im);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(bit st, int k, bit v, int s, int ri, int rq);
        @(negedge clk);
        start_i        = st;
        count_i        = CNT_W'(k);
        sample_valid_i = v;
        sample_i       = DATA_W'(s);
        ref_inph_i     = REF_W'(ri);
        ref_quad_i     = REF_W'(rq);
    endtask

    function automatic int rnd_s();
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    task automatic feed(int k, int gap_mod);
        for (int i = 0; i < k; i++) begin
            int s, ri, rq;
            if (gap_mod > 0 && (i % gap_mod) == 1) begin
                drive(1'b0, 0, 1'b0, rnd_s(), rnd_s(), rnd_s());
            end
            s = rnd_s(); ri = rnd_s(); rq = rnd_s();
            drive(1'b0, 0, 1'b1, s, ri, rq);
            sum_re += longint'(s) * longint'(ri);
            sum_im += longint'(s) * longint'(rq);
        end
    endtask

    task automatic finish_run(string tag);
        drive(1'b0, 0, 1'b0, 0, 0, 0);
        check("R5", {tag, " done pulse"}, longint'(done_o), 1);
        check("R5", {tag, " not busy at done"}, longint'(busy_o), 0);
        check(tag, "final in-phase sum", longint'($signed(acc_inph_o)), wrapv(sum_re));
        check(tag, "final quadrature sum", longint'($signed(acc_quad_o)), wrapv(sum_im));
        drive(1'b0, 0, 1'b0, 0, 0, 0);
        check("R5", {tag, " done lasts one cycle"}, longint'(done_o), 0);
    endtask

    task automatic run(int k, int gap_mod, string tag);
        sum_re = 0; sum_im = 0;
        drive(1'b1, k, 1'b0, 0, 0, 0);
        drive(1'b0, 0, 1'b0, 0, 0, 0);
        check("R2", "busy after start", longint'(busy_o), 1);
        check("R2", "cleared after start", longint'($signed(acc_inph_o)), 0);
        feed(k, gap_mod);
        finish_run(tag);
    endtask

    initial begin
        void'($urandom(13));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", longint'(busy_o), 0);
        check("R1", "done in reset", longint'(done_o), 0);
        check("R1", "acc_inph in reset", longint'($signed(acc_inph_o)), 0);
        check("R1", "acc_quad in reset", longint'($signed(acc_quad_o)), 0);
        rst_n = 1'b1;
        drive(1'b0, 0, 1'b0, 0, 0, 0);
        check("R1", "idle after reset", longint'(busy_o | done_o), 0);

        // R3: back-to-back samples
        run(4, 0, "R3");
        // R4: gaps inside the run
        run(6, 2, "R4");

        // R7: samples after done are ignored, results held
        for (int i = 0; i < 5; i++) drive(1'b0, 0, 1'b1, rnd_s(), rnd_s(), rnd_s());
        drive(1'b0, 0, 1'b0, 0, 0, 0);
        check("R7", "held in-phase", longint'($signed(acc_inph_o)), wrapv(sum_re));
        check("R7", "held quadrature", longint'($signed(acc_quad_o)), wrapv(sum_im));
        check("R7", "no done while idle", longint'(done_o), 0);

        // R8: zero count
        drive(1'b1, 0, 1'b1, 100, 100, 100);
        drive(1'b0, 0, 1'b0, 0, 0, 0);
        check("R8", "done after empty start", longint'(done_o), 1);
        check("R8", "not busy", longint'(busy_o), 0);
        check("R8", "in-phase zero", longint'($signed(acc_inph_o)), 0);
        check("R8", "quadrature zero", longint'($signed(acc_quad_o)), 0);

        // R9: restart mid-run, start overrides a valid sample
        sum_re = 0; sum_im = 0;
        drive(1'b1, 5, 1'b0, 0, 0, 0);
        feed(2, 0);
        sum_re = 0; sum_im = 0;
        drive(1'b1, 3, 1'b1, 2047, 2047, 2047);
        drive(1'b0, 0, 1'b0, 0, 0, 0);
        check("R9", "cleared by restart", longint'($signed(acc_inph_o)), 0);
        check("R9", "busy after restart", longint'(busy_o), 1);
        feed(3, 0);
        finish_run("R9");

        // R6: wrap with no saturation
        sum_re = 0; sum_im = 0;
        drive(1'b1, 40, 1'b0, 0, 0, 0);
        for (int i = 0; i < 40; i++) drive(1'b0, 0, 1'b1, -2048, -2048, 2047);
        drive(1'b0, 0, 1'b0, 0, 0, 0);
        check("R6", "in-phase wrapped", longint'($signed(acc_inph_o)), -100663296);
        check("R6", "quadrature wrapped", longint'($signed(acc_quad_o)), 100745216);
        check("R6", "done after wrap run", longint'(done_o), 1);

        // R3 sweep of counts, R5 maximum count
        run(1, 0, "R3");
        run(7, 3, "R3");
        run(20, 4, "R4");
        run(255, 5, "R5");

        repeat (3) drive(1'b0, 0, 1'b0, 0, 0, 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule